// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible register file of a sixteen-channel peripheral DMA controller. It sits on a plain memory-mapped bus with a write strobe, a byte address and combinational read data, and it holds everything software uses to steer the channel engines. Each channel has a control/status word, and a next-descriptor address register. Two global words hold the byte-alignment permits and a read-only summary of pending interrupts. A table of sixty-four entries maps each peripheral request line onto a channel. Descriptor fetching and data movement stay inside the channel engines, which this block drives and observes.

Each engine reports a stopped state and a request-pending flag as levels. It reports an end-of-transfer interrupt and a bus error as single-cycle pulses. The pulses latch into cause bits that software acknowledges by writing back the word it just read: cause bits are cleared by writing one, and the run and no-fetch controls are rewritten with the values they already hold. The OR of all pending causes drives one interrupt line. Request lines with a valid table entry are steered to the selected channel's request output. Lines without one are dropped.

Top module: `dmaChanRegs`

## Requirements
- R1: After reset every stored bit is zero. Every readback returns zero apart from bits that mirror engine inputs, and `irqOut`, `chanRun`, `chanNoDesc`, `byteAlignEn` and `nextDesc` are all low.
- R2: The control/status word of channel c is at byte address 4*c. Bit 31 (run) and bit 30 (no-descriptor-fetch) are read/write and drive `chanRun[c]` and `chanNoDesc[c]` from the cycle after the write.
- R3: In the control/status word, bit 8 shows `engReqPend[c]` and bit 3 shows `engStopped[c]` in the same cycle. Writes to these bits have no effect, and all other bits of the word read zero.
- R4: A pulse on `engEndIrq[c]` sets bit 2 of channel c's word, and a pulse on `engBusErr[c]` sets bit 0. Both stay set until software clears them.
- R5: Writing 1 to bit 2 or bit 0 clears that cause, and writing 0 leaves it alone. Writing back a value just read therefore acknowledges the causes and keeps run and no-fetch unchanged.
- R6: An engine event in the same cycle as a write that clears the same cause leaves the cause set.
- R7: The read-only word at 0x0F0 has bit c set while channel c has bit 2 or bit 0 set. Writes to it are ignored.
- R8: `irqOut` is high exactly while any bit of the 0x0F0 word is set.
- R9: The word at 0x0A0 holds one read/write alignment permit per channel in bits 15:0, which drive `byteAlignEn`. Upper bits read zero.
- R10: The mapping entry for request line l is at 0x100 + 4*l. Bit 7 is map-valid and bits 3:0 select the channel. `chanReq[c]` is the OR of `periphReq[l]` over all valid entries that select c.
- R11: A request line whose entry has bit 7 clear, including one that was cleared by writing zero, never reaches `chanReq`.
- R12: The next-descriptor register of channel c is at 0x200 + 16*c. It is a full 32-bit read/write register and drives `nextDesc[32*c +: 32]`.
- R13: Misaligned addresses and addresses outside the ranges above read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| chanRun | output | 16 | Per-channel run control |
| chanNoDesc | output | 16 | Per-channel no-descriptor-fetch control |
| byteAlignEn | output | 16 | Per-channel byte-alignment permit |
| nextDesc | output | 512 | Next-descriptor address, 32 bits per channel |
| engStopped | input | 16 | Engine stopped-state level per channel |
| engReqPend | input | 16 | Engine request-pending level per channel |
| engEndIrq | input | 16 | End-of-transfer interrupt pulse per channel |
| engBusErr | input | 16 | Bus-error pulse per channel |
| periphReq | input | 64 | Peripheral request lines |
| chanReq | output | 16 | Routed request per channel |
| irqOut | output | 1 | Combined interrupt |

## Verification
The key collision is an engine pulse arriving in the same cycle as a software write-back that clears the same cause. The bench provokes it on purpose: on channel 4 it pulses an end interrupt in the very cycle that the word is written with both cause bits set. The random phase then mixes event pulses with cause-clearing writes over many cycles. The reference model applies "set beats clear" for each cause independently, and the bench compares readback, the global word, the interrupt line and every output against it on each clock. A cause lost to a same-cycle clear therefore shows up as a miscompare.

// File: rtl/dmaChanRegs_pkg.sv
package dmaChanRegs_pkg;

  // address map (byte addresses)
  localparam int ALIGN_ADDR = 'h0A0;
  localparam int IRQ_ADDR   = 'h0F0;
  localparam int MAP_BASE   = 'h100;
  localparam int DESC_BASE  = 'h200;

  // control/status word bit positions
  localparam int RUN_BIT     = 31;
  localparam int NODESC_BIT  = 30;
  localparam int REQPEND_BIT = 8;
  localparam int STOP_BIT    = 3;
  localparam int ENDC_BIT    = 2;
  localparam int BUSERR_BIT  = 0;

  // mapping entry valid bit
  localparam int MAPVALID_BIT = 7;

  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    RD_NONE  = 3'd0,
    RD_CS    = 3'd1,
    RD_ALIGN = 3'd2,
    RD_IRQ   = 3'd3,
    RD_MAP   = 3'd4,
    RD_DESC  = 3'd5
  } rdSel_t;

  // strobes from decode to storage
  typedef struct packed {
    logic             csWr;
    logic             alignWr;
    logic             mapWr;
    logic             descWr;
    rdSel_t           rdSel;
    logic [IDX_W-1:0] idx;
  } regStrobe_t;

endpackage

// File: rtl/dmaRegDecode.sv
module dmaRegDecode
  import dmaChanRegs_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_MAP = 64,
  parameter int ADDR_W  = 12
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strobe
);

  localparam int CS_END   = NUM_CH * 4;
  localparam int MAP_END  = MAP_BASE + NUM_MAP * 4;
  localparam int DESC_END = DESC_BASE + NUM_CH * 16;

  logic [ADDR_W-1:0] mapOff;
  logic [ADDR_W-1:0] descOff;

  assign mapOff  = regAddr - ADDR_W'(MAP_BASE);
  assign descOff = regAddr - ADDR_W'(DESC_BASE);

  always_comb begin
    strobe = '0;
    if (regAddr[1:0] == 2'b00) begin
      if (regAddr < ADDR_W'(CS_END)) begin
        strobe.rdSel = RD_CS;
        strobe.idx   = IDX_W'(regAddr >> 2);
        strobe.csWr  = regWrEn;
      end else if (regAddr == ADDR_W'(ALIGN_ADDR)) begin
        strobe.rdSel   = RD_ALIGN;
        strobe.alignWr = regWrEn;
      end else if (regAddr == ADDR_W'(IRQ_ADDR)) begin
        strobe.rdSel = RD_IRQ;
      end else if (regAddr >= ADDR_W'(MAP_BASE) && regAddr < ADDR_W'(MAP_END)) begin
        strobe.rdSel = RD_MAP;
        strobe.idx   = IDX_W'(mapOff >> 2);
        strobe.mapWr = regWrEn;
      end else if (regAddr >= ADDR_W'(DESC_BASE) && regAddr < ADDR_W'(DESC_END)
                   && regAddr[3:2] == 2'b00) begin
        strobe.rdSel  = RD_DESC;
        strobe.idx    = IDX_W'(descOff >> 4);
        strobe.descWr = regWrEn;
      end
    end
  end

endmodule

// File: rtl/dmaRegStore.sv
module dmaRegStore
  import dmaChanRegs_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_MAP = 64,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              strobe,
  input  logic [31:0]             wrData,
  input  logic [NUM_CH-1:0]       engStopped,
  input  logic [NUM_CH-1:0]       engReqPend,
  input  logic [NUM_CH-1:0]       engEndIrq,
  input  logic [NUM_CH-1:0]       engBusErr,
  output logic [31:0]             rdData,
  output logic [NUM_CH-1:0]       chanRun,
  output logic [NUM_CH-1:0]       chanNoDesc,
  output logic [NUM_CH-1:0]       byteAlignEn,
  output logic [NUM_CH*32-1:0]    nextDesc,
  output logic [NUM_CH-1:0]       intPend,
  output logic [NUM_MAP-1:0]      mapValid,
  output logic [NUM_MAP*CH_W-1:0] mapChanFlat
);

  logic [NUM_CH-1:0] runQ, noDescQ, endCauseQ, busErrQ, alignQ;
  logic [NUM_CH-1:0] csHit, clrEnd, clrBus;
  logic [31:0]       descQ    [NUM_CH];
  logic [NUM_MAP-1:0] mapValidQ;
  logic [CH_W-1:0]   mapChanQ [NUM_MAP];

  // per-channel write hits and W1C requests
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      csHit[c]  = strobe.csWr && (strobe.idx == IDX_W'(c));
      clrEnd[c] = csHit[c] && wrData[ENDC_BIT];
      clrBus[c] = csHit[c] && wrData[BUSERR_BIT];
    end
  end

  // control bits and latched causes; a new event beats a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ      <= '0;
      noDescQ   <= '0;
      endCauseQ <= '0;
      busErrQ   <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (csHit[c]) begin
          runQ[c]    <= wrData[RUN_BIT];
          noDescQ[c] <= wrData[NODESC_BIT];
        end
      end
      endCauseQ <= engEndIrq | (endCauseQ & ~clrEnd);
      busErrQ   <= engBusErr | (busErrQ & ~clrBus);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alignQ <= '0;
    end else if (strobe.alignWr) begin
      alignQ <= wrData[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) descQ[c] <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (strobe.descWr && strobe.idx == IDX_W'(c)) descQ[c] <= wrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapValidQ <= '0;
      for (int l = 0; l < NUM_MAP; l++) mapChanQ[l] <= '0;
    end else begin
      for (int l = 0; l < NUM_MAP; l++) begin
        if (strobe.mapWr && strobe.idx == IDX_W'(l)) begin
          mapValidQ[l] <= wrData[MAPVALID_BIT];
          mapChanQ[l]  <= wrData[CH_W-1:0];
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_descOut
    assign nextDesc[c*32 +: 32] = descQ[c];
  end

  for (genvar l = 0; l < NUM_MAP; l++) begin : g_mapOut
    assign mapChanFlat[l*CH_W +: CH_W] = mapChanQ[l];
  end

  assign chanRun     = runQ;
  assign chanNoDesc  = noDescQ;
  assign byteAlignEn = alignQ;
  assign intPend     = endCauseQ | busErrQ;
  assign mapValid    = mapValidQ;

  // read mux
  always_comb begin
    rdData = '0;
    unique case (strobe.rdSel)
      RD_CS: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (strobe.idx == IDX_W'(c)) begin
            rdData[RUN_BIT]     = runQ[c];
            rdData[NODESC_BIT]  = noDescQ[c];
            rdData[REQPEND_BIT] = engReqPend[c];
            rdData[STOP_BIT]    = engStopped[c];
            rdData[ENDC_BIT]    = endCauseQ[c];
            rdData[BUSERR_BIT]  = busErrQ[c];
          end
        end
      end
      RD_ALIGN: rdData[NUM_CH-1:0] = alignQ;
      RD_IRQ:   rdData[NUM_CH-1:0] = endCauseQ | busErrQ;
      RD_MAP: begin
        for (int l = 0; l < NUM_MAP; l++) begin
          if (strobe.idx == IDX_W'(l)) begin
            rdData[MAPVALID_BIT] = mapValidQ[l];
            rdData[CH_W-1:0]     = mapChanQ[l];
          end
        end
      end
      RD_DESC: begin
        for (int c = 0; c < NUM_CH; c++) begin
          if (strobe.idx == IDX_W'(c)) rdData = descQ[c];
        end
      end
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/dmaReqRoute.sv
module dmaReqRoute #(
  parameter int NUM_CH  = 16,
  parameter int NUM_MAP = 64,
  parameter int CH_W    = $clog2(NUM_CH)
) (
  input  logic [NUM_MAP-1:0]      periphReq,
  input  logic [NUM_MAP-1:0]      mapValid,
  input  logic [NUM_MAP*CH_W-1:0] mapChanFlat,
  output logic [NUM_CH-1:0]       chanReq
);

  always_comb begin
    chanReq = '0;
    for (int l = 0; l < NUM_MAP; l++) begin
      if (periphReq[l] && mapValid[l]) begin
        chanReq[mapChanFlat[l*CH_W +: CH_W]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dmaChanRegs.sv
module dmaChanRegs
  import dmaChanRegs_pkg::*;
#(
  parameter int NUM_CH  = 16,
  parameter int NUM_MAP = 64,
  parameter int ADDR_W  = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWrData,
  output logic [31:0]         regRdData,
  output logic [NUM_CH-1:0]   chanRun,
  output logic [NUM_CH-1:0]   chanNoDesc,
  output logic [NUM_CH-1:0]   byteAlignEn,
  output logic [NUM_CH*32-1:0] nextDesc,
  input  logic [NUM_CH-1:0]   engStopped,
  input  logic [NUM_CH-1:0]   engReqPend,
  input  logic [NUM_CH-1:0]   engEndIrq,
  input  logic [NUM_CH-1:0]   engBusErr,
  input  logic [NUM_MAP-1:0]  periphReq,
  output logic [NUM_CH-1:0]   chanReq,
  output logic                irqOut
);

  localparam int CH_W = $clog2(NUM_CH);

  regStrobe_t               strobe;
  logic [NUM_CH-1:0]        intPend;
  logic [NUM_MAP-1:0]       mapValid;
  logic [NUM_MAP*CH_W-1:0]  mapChanFlat;

  dmaRegDecode #(.NUM_CH(NUM_CH), .NUM_MAP(NUM_MAP), .ADDR_W(ADDR_W)) u_decode (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  dmaRegStore #(.NUM_CH(NUM_CH), .NUM_MAP(NUM_MAP), .CH_W(CH_W)) u_store (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .wrData      (regWrData),
    .engStopped  (engStopped),
    .engReqPend  (engReqPend),
    .engEndIrq   (engEndIrq),
    .engBusErr   (engBusErr),
    .rdData      (regRdData),
    .chanRun     (chanRun),
    .chanNoDesc  (chanNoDesc),
    .byteAlignEn (byteAlignEn),
    .nextDesc    (nextDesc),
    .intPend     (intPend),
    .mapValid    (mapValid),
    .mapChanFlat (mapChanFlat)
  );

  dmaReqRoute #(.NUM_CH(NUM_CH), .NUM_MAP(NUM_MAP), .CH_W(CH_W)) u_route (
    .periphReq   (periphReq),
    .mapValid    (mapValid),
    .mapChanFlat (mapChanFlat),
    .chanReq     (chanReq)
  );

  assign irqOut = |intPend;

endmodule

// File: rtl/dmaChanRegs_chk.sv
module dmaChanRegs_chk #(
  parameter int NUM_CH  = 16,
  parameter int NUM_MAP = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [NUM_CH-1:0]    engEndIrq,
  input logic [NUM_CH-1:0]    engBusErr,
  input logic                 irqOut,
  input logic [NUM_CH-1:0]    chanRun,
  input logic [NUM_CH-1:0]    byteAlignEn,
  input logic [NUM_CH*32-1:0] nextDesc,
  input logic [NUM_MAP-1:0]   periphReq,
  input logic [NUM_CH-1:0]    chanReq
);

  AST_END_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (|engEndIrq) |=> irqOut);  // R6

  AST_BUSERR_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (|engBusErr) |=> irqOut);  // R4

  AST_IRQ_NEEDS_WRITE_TO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !regWrEn) |=> irqOut);  // R5

  AST_RUN_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(chanRun));  // R2

  AST_ALIGN_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(byteAlignEn));  // R9

  AST_DESC_STABLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(nextDesc));  // R12

  AST_NO_REQ_NO_ROUTE: assert property (@(posedge clk) disable iff (!rstN)
    (periphReq == '0) |-> (chanReq == '0));  // R11

endmodule

bind dmaChanRegs dmaChanRegs_chk #(.NUM_CH(NUM_CH), .NUM_MAP(NUM_MAP)) u_chk (.*);

// File: tb/dmaChanRegs_test.sv
module dmaChanRegs_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         regWrEn = 1'b0;
  logic [11:0]  regAddr = '0;
  logic [31:0]  regWrData = '0;
  logic [31:0]  regRdData;
  logic [15:0]  chanRun, chanNoDesc, byteAlignEn, chanReq;
  logic [511:0] nextDesc;
  logic [15:0]  engStopped = '0, engReqPend = '0, engEndIrq = '0, engBusErr = '0;
  logic [63:0]  periphReq = '0;
  logic         irqOut;

  int vectors = 0;
  int fails = 0;

  always #4ns clk = ~clk;  // 125 MHz

  dmaChanRegs uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .chanRun(chanRun),
    .chanNoDesc(chanNoDesc), .byteAlignEn(byteAlignEn), .nextDesc(nextDesc),
    .engStopped(engStopped), .engReqPend(engReqPend), .engEndIrq(engEndIrq),
    .engBusErr(engBusErr), .periphReq(periphReq), .chanReq(chanReq), .irqOut(irqOut)
  );

  // ---------------- behavioural reference model ----------------
  logic [15:0] mRun = '0, mNd = '0, mEnd = '0, mBus = '0, mAlign = '0;
  logic [31:0] mDesc [16] = '{default: '0};
  logic        mMapV [64] = '{default: 1'b0};
  int          mMapC [64] = '{default: 0};

  always @(posedge clk) begin
    int a;
    logic [15:0] clrE, clrB;
    clrE = '0;
    clrB = '0;
    if (!rstN) begin
      mRun = '0; mNd = '0; mEnd = '0; mBus = '0; mAlign = '0;
      for (int i = 0; i < 16; i++) mDesc[i] = '0;
      for (int i = 0; i < 64; i++) begin mMapV[i] = 1'b0; mMapC[i] = 0; end
    end else begin
      a = int'(regAddr);
      if (regWrEn && (a % 4) == 0) begin
        if (a < 64) begin
          mRun[a/4] = regWrData[31];
          mNd[a/4]  = regWrData[30];
          clrE[a/4] = regWrData[2];
          clrB[a/4] = regWrData[0];
        end else if (a == 'h0A0) begin
          mAlign = regWrData[15:0];
        end else if (a >= 'h100 && a < 'h200) begin
          mMapV[(a - 'h100) / 4] = regWrData[7];
          mMapC[(a - 'h100) / 4] = int'(regWrData[3:0]);
        end else if (a >= 'h200 && a < 'h300 && (a % 16) == 0) begin
          mDesc[(a - 'h200) / 16] = regWrData;
        end
      end
      mEnd = engEndIrq | (mEnd & ~clrE);
      mBus = engBusErr | (mBus & ~clrB);
    end
  end

  function automatic logic [31:0] expRead(int a);
    logic [31:0] w;
    w = '0;
    if ((a % 4) != 0) return w;
    if (a < 64) begin
      w[31] = mRun[a/4]; w[30] = mNd[a/4]; w[8] = engReqPend[a/4];
      w[3] = engStopped[a/4]; w[2] = mEnd[a/4]; w[0] = mBus[a/4];
    end else if (a == 'h0A0) w[15:0] = mAlign;
    else if (a == 'h0F0) w[15:0] = mEnd | mBus;
    else if (a >= 'h100 && a < 'h200) begin
      w[7] = mMapV[(a - 'h100) / 4];
      w[3:0] = 4'(mMapC[(a - 'h100) / 4]);
    end else if (a >= 'h200 && a < 'h300 && (a % 16) == 0) w = mDesc[(a - 'h200) / 16];
    return w;
  endfunction

  function automatic string regionTag(int a);
    if ((a % 4) != 0) return "R13";
    if (a < 64) return "R4";
    if (a == 'h0A0) return "R9";
    if (a == 'h0F0) return "R7";
    if (a >= 'h100 && a < 'h200) return "R10";
    if (a >= 'h200 && a < 'h300 && (a % 16) == 0) return "R12";
    return "R13";
  endfunction

  task automatic chk(string tag, logic [511:0] act, logic [511:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic checkAll();
    logic [15:0]  eReq;
    logic [511:0] eDesc;
    eReq = '0;
    for (int l = 0; l < 64; l++) if (periphReq[l] && mMapV[l]) eReq[mMapC[l]] = 1'b1;
    for (int c = 0; c < 16; c++) eDesc[c*32 +: 32] = mDesc[c];
    chk({regionTag(int'(regAddr)), " readback"}, 512'(regRdData), 512'(expRead(int'(regAddr))));
    chk("R2 chanRun", 512'(chanRun), 512'(mRun));
    chk("R2 chanNoDesc", 512'(chanNoDesc), 512'(mNd));
    chk("R8 irqOut", 512'(irqOut), 512'(|(mEnd | mBus)));
    chk("R9 byteAlignEn", 512'(byteAlignEn), 512'(mAlign));
    chk("R10 chanReq", 512'(chanReq), 512'(eReq));
    chk("R12 nextDesc", nextDesc, eDesc);
  endtask

  task automatic tick();
    @(negedge clk);
    checkAll();
  endtask

  task automatic wr(int a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = 12'(a); regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic rd(int a);
    regAddr = 12'(a);
    tick();
  endtask

  initial begin
    #(8ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state on every output and a few readbacks
    tick();
    chk("R1 irqOut reset", 512'(irqOut), 512'(0));
    chk("R1 chanRun reset", 512'(chanRun), 512'(0));
    rd('h0F0); rd('h100); rd('h200); rd('h0A0);

    // R2: run on ch3, no-fetch on ch5
    wr('h00C, 32'h8000_0000); rd('h00C);
    wr('h014, 32'h4000_0000); rd('h014);

    // R3: engine levels mirrored; writes to read-only bits ignored
    engReqPend = 16'h0008; engStopped = 16'h0020;
    rd('h00C); rd('h014);
    wr('h018, 32'h0000_0108); rd('h018);
    engReqPend = 16'h0040; rd('h018);

    // R4: cause latching on ch2 and ch9
    engEndIrq = 16'h0004; rd('h008); engEndIrq = '0;
    rd('h008); rd('h0F0);
    engBusErr = 16'h0200; rd('h024); engBusErr = '0;
    rd('h024); rd('h0F0);

    // R5: writing zero keeps causes; echo acknowledges and keeps run
    wr('h008, 32'h8000_0000); rd('h008);
    wr('h008, 32'h8000_0004); rd('h008);
    wr('h024, 32'h0000_0001); rd('h024); rd('h0F0);

    // R6: event and clear on the same channel in the same cycle
    engBusErr = 16'h0010; rd('h010); engBusErr = '0;
    engEndIrq = 16'h0010;
    wr('h010, 32'h0000_0005);
    engEndIrq = '0;
    rd('h010);

    // R7: global word is read-only
    wr('h0F0, 32'h0000_0000); rd('h0F0);
    wr('h010, 32'h0000_0004); rd('h0F0);

    // R9: alignment permits
    wr('h0A0, 32'h0000_A5A5); rd('h0A0);
    wr('h0A0, 32'hFFFF_0001); rd('h0A0);

    // R10: routing, two lines to one channel, last line
    wr('h100 + 4*10, 32'h86); rd('h100 + 4*10);
    periphReq = 64'h0000_0000_0000_0400; rd('h0F0);
    wr('h100 + 4*11, 32'h86);
    periphReq = 64'h0000_0000_0000_0800; rd('h0F0);
    wr('h100 + 4*63, 32'h8F);
    periphReq = 64'h8000_0000_0000_0C00; rd('h100 + 4*63);

    // R11: entry without valid bit, then unmapping by writing zero
    wr('h100 + 4*20, 32'h03);
    periphReq = 64'h0000_0000_0010_0000; rd('h100 + 4*20);
    wr('h100 + 4*10, 32'h0);
    periphReq = 64'h0000_0000_0000_0400; rd('h100 + 4*10);
    periphReq = '0;

    // R12: descriptor registers
    wr('h2F0, 32'hDEAD_BEEF); rd('h2F0);
    wr('h200, 32'h1234_5678); rd('h200);

    // R13: holes and misaligned accesses
    wr('h0A4, 32'hFFFF_FFFF); rd('h0A4);
    wr('h204, 32'h0000_0001); rd('h200); rd('h204);
    wr('h00E, 32'h8000_0000); rd('h00E); rd('h00C);
    rd('h3FC);

    // random phase: collisions of events and write-backs (R4 R5 R6)
    for (int i = 0; i < 3000; i++) begin
      int sel;
      int a;
      sel = int'($urandom % 6);
      case (sel)
        0: a = 4 * int'($urandom % 16);
        1: a = 'h0A0;
        2: a = 'h0F0;
        3: a = 'h100 + 4 * int'($urandom % 64);
        4: a = 'h200 + 16 * int'($urandom % 16);
        default: a = int'($urandom % 1024);
      endcase
      regWrEn   = (($urandom % 3) == 0);
      regAddr   = 12'(a);
      regWrData = $urandom;
      engEndIrq = (($urandom % 4) == 0) ? 16'($urandom & $urandom) : '0;
      engBusErr = (($urandom % 6) == 0) ? 16'($urandom & $urandom) : '0;
      engStopped = 16'($urandom);
      engReqPend = 16'($urandom);
      periphReq  = {$urandom, $urandom};
      tick();
    end
    regWrEn = 1'b0; engEndIrq = '0; engBusErr = '0;
    rd('h0F0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule